// File: doc/BRIEF.md
# Periodic Split-Transaction Microframe Scheduler

This block keeps one periodic (interrupt) split-transaction descriptor for a high-speed host controller. The host reaches a full- or low-speed device through a hub. Software loads a direction, a 5-bit target frame number and two per-microframe bitmasks: one for start-splits and one for complete-splits. At each microframe start the block checks the current microframe against the masks and the stored frame number. When the slot is due, it asks a transaction engine to issue exactly one split token.

After the engine accepts the token, the block waits for the result. When the result arrives, in a single clock edge the block:
- stores the 3-bit status for that microframe,
- stores the received byte count (complete-splits only),
- clears the mask bit that was served.

A sticky completion flag reports when every requested split has been served. Software reads back the masks, the flag and any microframe's status and byte count through a select input.

Top module: `psplit_sched`

## Requirements
- R1: After reset both masks read 0, `tok_req` is 0, `done` is 0, and every microframe reads status 0 and byte count 0.
- R2: A software write loads direction and frame, and ORs its set-bit vectors into the masks. Zero bits in a write never clear a pending mask bit.
- R3: A start-split is requested when `uframe_start` arrives with microframe u, the start-split bit u is set and `bus_frame` equals the stored frame. `tok_req` rises one cycle later with `tok_kind`=0 and `tok_uframe`=u, and holds all three until `tok_ack`.
- R4: If `bus_frame` differs from the stored frame, no token is requested.
- R5: For IN (direction 1), start-split bits 4..7 of a write are discarded and never cause a start-split. Only bits 0..3 are kept.
- R6: A complete-split (`tok_kind`=1) is requested only for IN, with the complete-split bit u set and a frame match. For OUT writes the complete-split set bits are discarded.
- R7: If both masks have bit u set, the start-split is issued first and the complete-split bit stays pending.
- R8: On `res_valid` after an accepted token, the edge stores `res_status` for that microframe and clears the served mask bit. The byte count is overwritten with `res_bytes` only for a complete-split result.
- R9: Only one token is in flight. A `uframe_start` seen while a request or result is outstanding is ignored.
- R10: `done` rises on the edge where both masks become zero after a write that set at least one bit. It clears on the next write that sets a mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sw_wr | input | 1 | Software descriptor write strobe |
| sw_is_in | input | 1 | Direction written: 1 = IN, 0 = OUT |
| sw_frame | input | 5 | Target frame number written |
| sw_ss_set | input | 8 | Start-split bits to set |
| sw_cs_set | input | 8 | Complete-split bits to set |
| bus_frame | input | 5 | Current bus frame number (low bits) |
| uframe | input | 3 | Current microframe index |
| uframe_start | input | 1 | One-cycle pulse at each microframe start |
| tok_req | output | 1 | Token issue request |
| tok_kind | output | 1 | 0 = start-split, 1 = complete-split |
| tok_uframe | output | 3 | Microframe of the current token |
| tok_ack | input | 1 | Engine accepted the token |
| res_valid | input | 1 | Engine result strobe |
| res_status | input | 3 | bit0 transaction error, bit1 babble, bit2 underrun |
| res_bytes | input | 8 | Bytes received |
| rd_sel | input | 3 | Microframe selected for readback |
| rd_status | output | 3 | Status of the selected microframe |
| rd_bytes | output | 8 | Byte count of the selected microframe |
| ss_mask | output | 8 | Pending start-split mask |
| cs_mask | output | 8 | Pending complete-split mask |
| done | output | 1 | All requested splits served |

## Verification
The latencies the checks rely on are:
- `tok_req`, `tok_kind` and `tok_uframe` follow `uframe_start` by one registered cycle.
- `tok_req` drops one cycle after the `tok_ack` edge.
- The masks, the status and byte-count stores and `done` change on the same edge that samples `res_valid` or `sw_wr`.
- The readback of status and byte count is combinational from `rd_sel`.

The bench drives every input at a falling edge. It samples outputs at the next falling edge, half a period after the single register stage, and compares them with a bench model updated at the same points. It also holds the engine for a random number of cycles, so that request holding and the ignoring of microframe starts while busy are both observed.

// File: rtl/psplit_pkg.sv
package psplit_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } psplit_state_e;

    typedef enum logic {
        TOK_SS = 1'b0,
        TOK_CS = 1'b1
    } psplit_tok_e;

endpackage

// File: rtl/psplit_pick.sv
module psplit_pick #(
    parameter int NUM_UF      = 8,
    parameter int IN_SS_SLOTS = 4,
    localparam int UF_W       = $clog2(NUM_UF)
) (
    input  logic [NUM_UF-1:0] ss_mask,
    input  logic [NUM_UF-1:0] cs_mask,
    input  logic              dir_in,
    input  logic              frame_match,
    input  logic [UF_W-1:0]   uf,
    output logic              hit,
    output psplit_pkg::psplit_tok_e kind
);
    import psplit_pkg::*;

    logic ss_ok;
    logic cs_ok;
    logic slot_early;

    always_comb begin
        slot_early = (int'(uf) < IN_SS_SLOTS);
        ss_ok      = ss_mask[uf] && frame_match && (!dir_in || slot_early);
        cs_ok      = cs_mask[uf] && frame_match && dir_in;
        hit        = ss_ok || cs_ok;
        kind       = ss_ok ? TOK_SS : TOK_CS;
    end

endmodule

// File: rtl/psplit_store.sv
module psplit_store #(
    parameter int NUM_UF = 8,
    parameter int ST_W   = 3,
    parameter int CNT_W  = 8,
    localparam int UF_W  = $clog2(NUM_UF)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [UF_W-1:0]  wr_uf,
    input  logic [ST_W-1:0]  wr_status,
    input  logic             wr_bytes_en,
    input  logic [CNT_W-1:0] wr_bytes,
    input  logic [UF_W-1:0]  rd_sel,
    output logic [ST_W-1:0]  rd_status,
    output logic [CNT_W-1:0] rd_bytes
);

    logic [ST_W-1:0]  st_q [NUM_UF];
    logic [CNT_W-1:0] by_q [NUM_UF];

    for (genvar g = 0; g < NUM_UF; g++) begin : g_slot
        typedef struct packed {
            logic [ST_W-1:0]  st;
            logic [CNT_W-1:0] by;
        } slot_t;

        slot_t slot_d, slot_q;
        logic  sel;

        always_comb begin
            sel    = wr_en && (wr_uf == UF_W'(g));
            slot_d = slot_q;
            if (sel) begin
                slot_d.st = wr_status;
                if (wr_bytes_en) begin
                    slot_d.by = wr_bytes;
                end
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot_q <= '0;
            end else begin
                slot_q <= slot_d;
            end
        end

        assign st_q[g] = slot_q.st;
        assign by_q[g] = slot_q.by;
    end

    assign rd_status = st_q[rd_sel];
    assign rd_bytes  = by_q[rd_sel];

endmodule

// File: rtl/psplit_sched.sv
module psplit_sched #(
    parameter int NUM_UF      = 8,
    parameter int FRM_W       = 5,
    parameter int ST_W        = 3,
    parameter int CNT_W       = 8,
    parameter int IN_SS_SLOTS = 4,
    localparam int UF_W       = $clog2(NUM_UF)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_wr,
    input  logic              sw_is_in,
    input  logic [FRM_W-1:0]  sw_frame,
    input  logic [NUM_UF-1:0] sw_ss_set,
    input  logic [NUM_UF-1:0] sw_cs_set,
    input  logic [FRM_W-1:0]  bus_frame,
    input  logic [UF_W-1:0]   uframe,
    input  logic              uframe_start,
    output logic              tok_req,
    output logic              tok_kind,
    output logic [UF_W-1:0]   tok_uframe,
    input  logic              tok_ack,
    input  logic              res_valid,
    input  logic [ST_W-1:0]   res_status,
    input  logic [CNT_W-1:0]  res_bytes,
    input  logic [UF_W-1:0]   rd_sel,
    output logic [ST_W-1:0]   rd_status,
    output logic [CNT_W-1:0]  rd_bytes,
    output logic [NUM_UF-1:0] ss_mask,
    output logic [NUM_UF-1:0] cs_mask,
    output logic              done
);
    import psplit_pkg::*;

    localparam logic [NUM_UF-1:0] IN_SS_OK = NUM_UF'((1 << IN_SS_SLOTS) - 1);

    typedef struct packed {
        psplit_state_e     state;
        logic [NUM_UF-1:0] ss_mask;
        logic [NUM_UF-1:0] cs_mask;
        logic              dir_in;
        logic [FRM_W-1:0]  frame;
        logic [UF_W-1:0]   cur_uf;
        psplit_tok_e       cur_kind;
        logic              armed;
        logic              done;
    } regs_t;

    regs_t d, q;

    logic              frame_match;
    logic              pick_hit;
    psplit_tok_e       pick_kind;
    logic              res_take;
    logic [NUM_UF-1:0] clr_ss;
    logic [NUM_UF-1:0] clr_cs;
    logic [NUM_UF-1:0] ss_set_eff;
    logic [NUM_UF-1:0] cs_set_eff;
    logic              set_any;
    logic              masks_empty_d;
    logic              busy;
    logic              dir_in_q;

    assign frame_match = (bus_frame == q.frame);

    psplit_pick #(
        .NUM_UF      (NUM_UF),
        .IN_SS_SLOTS (IN_SS_SLOTS)
    ) u_pick (
        .ss_mask     (q.ss_mask),
        .cs_mask     (q.cs_mask),
        .dir_in      (q.dir_in),
        .frame_match (frame_match),
        .uf          (uframe),
        .hit         (pick_hit),
        .kind        (pick_kind)
    );

    always_comb begin
        d = q;

        // result consumption and mask clearing
        res_take = (q.state == ST_WAIT) && res_valid;
        clr_ss   = '0;
        clr_cs   = '0;
        if (res_take) begin
            if (q.cur_kind == TOK_CS) begin
                clr_cs[q.cur_uf] = 1'b1;
            end else begin
                clr_ss[q.cur_uf] = 1'b1;
            end
        end

        // software set-only writes, filtered by the written direction
        ss_set_eff = sw_is_in ? (sw_ss_set & IN_SS_OK) : sw_ss_set;
        cs_set_eff = sw_is_in ? sw_cs_set : '0;
        set_any    = sw_wr && (|(ss_set_eff | cs_set_eff));

        d.ss_mask = (q.ss_mask & ~clr_ss) | (sw_wr ? ss_set_eff : '0);
        d.cs_mask = (q.cs_mask & ~clr_cs) | (sw_wr ? cs_set_eff : '0);
        if (sw_wr) begin
            d.dir_in = sw_is_in;
            d.frame  = sw_frame;
        end

        // token handshake sequencing
        unique case (q.state)
            ST_IDLE: begin
                if (uframe_start && pick_hit) begin
                    d.state    = ST_REQ;
                    d.cur_uf   = uframe;
                    d.cur_kind = pick_kind;
                end
            end
            ST_REQ: begin
                if (tok_ack) begin
                    d.state = ST_WAIT;
                end
            end
            ST_WAIT: begin
                if (res_valid) begin
                    d.state = ST_IDLE;
                end
            end
            default: d.state = ST_IDLE;
        endcase

        // completion flag
        masks_empty_d = (d.ss_mask == '0) && (d.cs_mask == '0);
        if (set_any) begin
            d.armed = 1'b1;
            d.done  = 1'b0;
        end else if (q.armed && masks_empty_d) begin
            d.armed = 1'b0;
            d.done  = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q <= '{state: ST_IDLE, cur_kind: TOK_SS, default: '0};
        end else begin
            q <= d;
        end
    end

    psplit_store #(
        .NUM_UF (NUM_UF),
        .ST_W   (ST_W),
        .CNT_W  (CNT_W)
    ) u_store (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (res_take),
        .wr_uf       (q.cur_uf),
        .wr_status   (res_status),
        .wr_bytes_en (q.cur_kind == TOK_CS),
        .wr_bytes    (res_bytes),
        .rd_sel      (rd_sel),
        .rd_status   (rd_status),
        .rd_bytes    (rd_bytes)
    );

    assign busy       = (q.state == ST_WAIT);
    assign dir_in_q   = q.dir_in;
    assign tok_req    = (q.state == ST_REQ);
    assign tok_kind   = q.cur_kind;
    assign tok_uframe = q.cur_uf;
    assign ss_mask    = q.ss_mask;
    assign cs_mask    = q.cs_mask;
    assign done       = q.done;

endmodule

// File: rtl/psplit_sched_chk.sv
module psplit_sched_chk #(
    parameter int NUM_UF      = 8,
    parameter int IN_SS_SLOTS = 4,
    localparam int UF_W       = $clog2(NUM_UF)
) (
    input logic              clk,
    input logic              rst_n,
    input logic              tok_req,
    input logic              tok_kind,
    input logic [UF_W-1:0]   tok_uframe,
    input logic              tok_ack,
    input logic              res_valid,
    input logic              sw_wr,
    input logic [NUM_UF-1:0] ss_mask,
    input logic [NUM_UF-1:0] cs_mask,
    input logic              done,
    input logic              dir_in,
    input logic              busy
);

    // R3: request and its attributes are held until accepted
    assert_req_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && !tok_ack) |=> (tok_req && $stable(tok_kind) && $stable(tok_uframe)));

    // R5: an IN start-split never targets a late microframe
    assert_in_ss_early_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && !tok_kind && dir_in) |-> (int'(tok_uframe) < IN_SS_SLOTS));

    // R6: complete-splits are for IN only
    assert_cs_in_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tok_req && tok_kind) |-> dir_in);

    // R8: the served mask bit is clear right after the result edge
    assert_mask_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && res_valid && !sw_wr) |=>
        ($past(tok_kind) ? !cs_mask[$past(tok_uframe)] : !ss_mask[$past(tok_uframe)]));

    // R9: no new request while a result is outstanding
    assert_single_flight_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !res_valid) |=> !tok_req);

    // R10: completion implies empty masks
    assert_done_empty_R10: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (ss_mask == '0 && cs_mask == '0));

endmodule

bind psplit_sched psplit_sched_chk #(
    .NUM_UF      (NUM_UF),
    .IN_SS_SLOTS (IN_SS_SLOTS)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .tok_req    (tok_req),
    .tok_kind   (tok_kind),
    .tok_uframe (tok_uframe),
    .tok_ack    (tok_ack),
    .res_valid  (res_valid),
    .sw_wr      (sw_wr),
    .ss_mask    (ss_mask),
    .cs_mask    (cs_mask),
    .done       (done),
    .dir_in     (dir_in_q),
    .busy       (busy)
);

// File: tb/psplit_sched_tb.sv
module psplit_sched_tb_top;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sw_wr = 1'b0;
    logic       sw_is_in = 1'b0;
    logic [4:0] sw_frame = '0;
    logic [7:0] sw_ss_set = '0;
    logic [7:0] sw_cs_set = '0;
    logic [4:0] bus_frame = '0;
    logic [2:0] uframe = '0;
    logic       uframe_start = 1'b0;
    logic       tok_req;
    logic       tok_kind;
    logic [2:0] tok_uframe;
    logic       tok_ack = 1'b0;
    logic       res_valid = 1'b0;
    logic [2:0] res_status = '0;
    logic [7:0] res_bytes = '0;
    logic [2:0] rd_sel = '0;
    logic [2:0] rd_status;
    logic [7:0] rd_bytes;
    logic [7:0] ss_mask;
    logic [7:0] cs_mask;
    logic       done;

    always #(CLK_PERIOD / 2) clk = ~clk;

    psplit_sched dut_i (
        .clk(clk), .rst_n(rst_n), .sw_wr(sw_wr), .sw_is_in(sw_is_in),
        .sw_frame(sw_frame), .sw_ss_set(sw_ss_set), .sw_cs_set(sw_cs_set),
        .bus_frame(bus_frame), .uframe(uframe), .uframe_start(uframe_start),
        .tok_req(tok_req), .tok_kind(tok_kind), .tok_uframe(tok_uframe),
        .tok_ack(tok_ack), .res_valid(res_valid), .res_status(res_status),
        .res_bytes(res_bytes), .rd_sel(rd_sel), .rd_status(rd_status),
        .rd_bytes(rd_bytes), .ss_mask(ss_mask), .cs_mask(cs_mask), .done(done)
    );

    int n_checks = 0;
    int n_fail   = 0;

    // bench model
    logic [7:0] m_ss, m_cs;
    logic       m_in, m_armed, m_done;
    logic [4:0] m_frame;
    logic [2:0] m_st [8];
    logic [7:0] m_by [8];

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic logic exp_hit(input int u, input logic [4:0] bf, output logic kind);
        logic ss_ok, cs_ok;
        ss_ok = m_ss[u] && (bf == m_frame) && (!m_in || u < 4);
        cs_ok = m_cs[u] && (bf == m_frame) && m_in;
        kind = ss_ok ? 1'b0 : 1'b1;
        return ss_ok || cs_ok;
    endfunction

    task automatic check_state(input string req);
        chk({req, " ss_mask"}, ss_mask, m_ss);
        chk({req, " cs_mask"}, cs_mask, m_cs);
        chk({req, " done"}, done, m_done);
    endtask

    task automatic check_slots(input string req);
        for (int i = 0; i < 8; i++) begin
            rd_sel = 3'(i);
            #1;
            chk({req, " slot status"}, rd_status, m_st[i]);
            chk({req, " slot bytes"}, rd_bytes, m_by[i]);
        end
    endtask

    task automatic sw_write(input logic is_in, input logic [4:0] fr,
                            input logic [7:0] ss, input logic [7:0] cs);
        logic [7:0] es, ec;
        @(negedge clk);
        sw_wr = 1'b1; sw_is_in = is_in; sw_frame = fr; sw_ss_set = ss; sw_cs_set = cs;
        @(negedge clk);
        sw_wr = 1'b0; sw_ss_set = '0; sw_cs_set = '0;
        es = is_in ? (ss & 8'h0F) : ss;
        ec = is_in ? cs : 8'h00;
        m_ss |= es; m_cs |= ec; m_in = is_in; m_frame = fr;
        if ((es | ec) != 0) begin
            m_armed = 1'b1; m_done = 1'b0;
        end
        check_state("R2");
    endtask

    // one microframe: start pulse, optional handshake and result
    task automatic run_uf(input int u, input logic [4:0] bf, input int ack_wait,
                          input logic [2:0] st, input logic [7:0] by, input logic poke_busy);
        logic hit, kind;
        hit = exp_hit(u, bf, kind);
        @(negedge clk);
        uframe_start = 1'b1; uframe = 3'(u); bus_frame = bf;
        @(negedge clk);
        uframe_start = 1'b0;
        chk("R3/R4 tok_req", tok_req, hit);
        if (!hit) return;
        chk(kind ? "R6/R7 tok_kind" : "R3/R7 tok_kind", tok_kind, kind);
        chk("R3 tok_uframe", tok_uframe, u);
        for (int w = 0; w < ack_wait; w++) begin
            if (poke_busy) begin
                uframe_start = 1'b1; uframe = 3'(u + 1 + w); bus_frame = m_frame;
            end
            @(negedge clk);
            uframe_start = 1'b0;
        end
        chk("R3 hold tok_req", tok_req, 1);
        chk("R9 tok_uframe stable", tok_uframe, u);
        tok_ack = 1'b1;
        @(negedge clk);
        tok_ack = 1'b0;
        if (poke_busy) begin
            uframe_start = 1'b1; uframe = 3'(u + 1); bus_frame = m_frame;
        end
        @(negedge clk);
        uframe_start = 1'b0;
        chk("R9 no request while waiting", tok_req, 0);
        res_valid = 1'b1; res_status = st; res_bytes = by;
        @(negedge clk);
        res_valid = 1'b0;
        m_st[u] = st;
        if (kind) begin
            m_cs[u] = 1'b0; m_by[u] = by;
        end else begin
            m_ss[u] = 1'b0;
        end
        if (m_armed && m_ss == 0 && m_cs == 0) begin
            m_armed = 1'b0; m_done = 1'b1;
        end
        chk("R9 idle after result", tok_req, 0);
        check_state("R8/R10");
        rd_sel = 3'(u);
        #1;
        chk("R8 status", rd_status, m_st[u]);
        chk("R8 bytes", rd_bytes, m_by[u]);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        n_fail++;
        n_checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        m_ss = '0; m_cs = '0; m_in = 0; m_armed = 0; m_done = 0; m_frame = '0;
        for (int i = 0; i < 8; i++) begin m_st[i] = '0; m_by[i] = '0; end
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        chk("R1 tok_req", tok_req, 0);
        check_state("R1");
        check_slots("R1");

        // R3 R6: start-split in uframe 0, complete-split in uframe 2
        sw_write(1'b1, 5'd5, 8'h01, 8'h04);
        run_uf(0, 5'd5, 0, 3'b000, 8'h11, 1'b0);
        run_uf(1, 5'd5, 0, 3'b000, 8'h00, 1'b0);
        run_uf(2, 5'd5, 2, 3'b010, 8'h2A, 1'b0);
        chk("R10 done after both served", done, 1);

        // R4 frame mismatch, OUT start-split in uframe 7
        sw_write(1'b0, 5'd3, 8'h80, 8'h00);
        chk("R10 done cleared by setting write", done, 0);
        run_uf(7, 5'd4, 0, 3'b000, 8'h00, 1'b0);
        run_uf(7, 5'd3, 1, 3'b101, 8'h77, 1'b0);
        chk("R8 OUT result leaves bytes", rd_bytes, 8'h00);

        // R5 late IN start-split bits dropped
        sw_write(1'b1, 5'd9, 8'hF0, 8'h00);
        chk("R5 late bits dropped", ss_mask, 8'h00);
        run_uf(4, 5'd9, 0, 3'b000, 8'h00, 1'b0);

        // R6 OUT complete-split bits dropped
        sw_write(1'b0, 5'd9, 8'h00, 8'hFF);
        chk("R6 OUT cs dropped", cs_mask, 8'h00);

        // R7 priority, R2 zero write keeps bits
        sw_write(1'b1, 5'd1, 8'h02, 8'h02);
        sw_write(1'b1, 5'd1, 8'h00, 8'h00);
        chk("R2 zero write keeps ss", ss_mask, 8'h02);
        run_uf(1, 5'd1, 0, 3'b001, 8'h05, 1'b0);
        chk("R7 cs still pending", cs_mask, 8'h02);
        run_uf(1, 5'd1, 0, 3'b011, 8'h09, 1'b0);

        // R9 microframe starts while busy are ignored
        sw_write(1'b1, 5'd2, 8'h0F, 8'hFF);
        run_uf(0, 5'd2, 3, 3'b000, 8'h01, 1'b1);
        chk("R9 other bits untouched", ss_mask, 8'h0E);

        // random mix
        for (int it = 0; it < 400; it++) begin
            int op;
            op = int'($urandom_range(0, 3));
            if (op == 0) begin
                sw_write(1'($urandom_range(0, 1)), 5'($urandom_range(0, 3)),
                         8'($urandom), 8'($urandom));
            end else begin
                run_uf(int'($urandom_range(0, 7)), 5'($urandom_range(0, 3)),
                       int'($urandom_range(0, 3)), 3'($urandom), 8'($urandom),
                       1'($urandom_range(0, 1)));
            end
        end
        check_slots("R8 final");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule